// File: doc/BRIEF.md
# Iterative Non-Restoring Integer Divider

This block divides a 64-bit dividend by a divisor over many clock cycles, forming one quotient bit per cycle with a non-restoring add/subtract recurrence. A single-cycle `start_i` pulse, taken only while the block is idle, captures the operands together with two mode bits. `signed_i` selects two's-complement or unsigned operands. `wide_i` selects between a full 64-bit quotient and a 32-bit quotient taken from a 32-bit divisor.

The iteration works on operand magnitudes. The final sign is applied in one extra cycle. A staged check then decides whether a 32-bit quotient fits, and replaces it with the nearest representable value when it does not. Eight condition flags describe the result in its 64-bit and 32-bit views.

The finished result is offered on `req_o` and stays there until the consumer raises `ack_i`. A synchronous `abort_i` throws away any operation in flight.

Top module: `nrdiv_unit`

## Requirements
- R1: A start pulse seen in idle is accepted at that clock edge, and `req_o` rises exactly 67 edges later: 64 iteration edges, then one edge each for sign, check and saturation.
- R2: Control is one-hot across six states, and the iteration counter reads zero whenever the previous cycle was not an iteration cycle, so each operation, including one that follows an abort, has the same latency.
- R3: With `wide_i`=1 the quotient is the 64-bit quotient truncated toward zero: unsigned when `signed_i`=0, two's complement when `signed_i`=1. Most-negative divided by minus one wraps to most-negative. A zero divisor gives an unspecified quotient.
- R4: With `wide_i`=0 only divisor bits 31:0 are used, sign-extended when signed and zero-extended when unsigned. A quotient that fits in 32 bits is returned sign-extended (signed) or zero-extended (unsigned) to 64 bits.
- R5: In 32-bit unsigned mode a quotient with any of bits 63:32 set is an overflow, and the result becomes 0x00000000FFFFFFFF.
- R6: In 32-bit signed mode a quotient above 2^31-1 saturates to 0x000000007FFFFFFF. This includes a negative dividend divided by a negative divisor that wraps, such as -2^31/-1. A quotient below -2^31 saturates to 0xFFFFFFFF80000000.
- R7: Flags `flags_o` have this layout:
  - [7] bit 63 of the 64-bit quotient.
  - [6] the 64-bit quotient is zero.
  - [5] and [4] are always 0.
  - [3] bit 31 of the final 32-bit result.
  - [2] the final 32-bit result is zero.
  - [1] 32-bit overflow (always 0 in wide mode).
  - [0] is always 0.
- R8: `req_o` and `quot_o` hold steady until `ack_i` is high at a clock edge. `req_o` is low after that edge.
- R9: `start_i` has no effect while an operation is running or a result is waiting.
- R10: `abort_i` high at a clock edge returns the block to idle from any state. The aborted operation never raises `req_o`.
- R11: Asserting `rst_n` low forces idle at once, with `req_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start pulse; operands sampled with it |
| signed_i | input | 1 | 1: two's-complement operands |
| wide_i | input | 1 | 1: 64-bit quotient; 0: 32-bit quotient from divisor bits 31:0 |
| dividend_i | input | 64 | Dividend |
| divisor_i | input | 64 | Divisor |
| abort_i | input | 1 | Synchronous abort to idle |
| ack_i | input | 1 | Consumer accepts the offered result |
| req_o | output | 1 | Result offered |
| quot_o | output | 64 | Quotient, saturated in 32-bit mode |
| flags_o | output | 8 | Condition flags, layout in R7 |

## Verification
On every cycle, the assertions check the following:
- the one-hot state and the counter clearing;
- the exit from iteration after the last count;
- that a waiting result holds without acknowledge;
- the return to idle on abort and on acknowledge;
- that the first step subtracts;
- that a narrow result is always a properly extended 32-bit value with zero and overflow flags never both set.

The numeric behaviour can only be shown by the bench's operand patterns: correct quotients in every mode, the exact overflow boundaries, saturation values and flag bits. The same holds for ignored start pulses, abort in mid-run and the exact latency.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

  typedef enum logic [5:0] {
    ST_IDLE = 6'b000001,
    ST_RUN  = 6'b000010,
    ST_LAST = 6'b000100,
    ST_CHK  = 6'b001000,
    ST_FIX  = 6'b010000,
    ST_DONE = 6'b100000
  } dstate_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccf_t;

endpackage

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl
  import nrdiv_pkg::*;
#(
  parameter int ITER = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic abort_i,
  input  logic ack_i,
  output logic ld_o,
  output logic step_o,
  output logic fin_o,
  output logic chk_o,
  output logic fix_o,
  output logic req_o
);

  localparam int CW = $clog2(ITER);
  localparam logic [CW-1:0] CLAST = CW'(ITER - 1);

  dstate_e st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    st_n = st_q;
    case (st_q)
      ST_IDLE: if (start_i) st_n = ST_RUN;
      ST_RUN:  if (cnt_q == CLAST) st_n = ST_LAST;
      ST_LAST: st_n = ST_CHK;
      ST_CHK:  st_n = ST_FIX;
      ST_FIX:  st_n = ST_DONE;
      ST_DONE: if (ack_i) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
    if (abort_i) st_n = ST_IDLE;
  end

  always_comb begin
    cnt_n = '0;
    if (st_q == ST_RUN) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  assign ld_o   = (st_q == ST_IDLE) && start_i && !abort_i;
  assign step_o = (st_q == ST_RUN);
  assign fin_o  = (st_q == ST_LAST);
  assign chk_o  = (st_q == ST_CHK);
  assign fix_o  = (st_q == ST_FIX);
  assign req_o  = (st_q == ST_DONE);

  // R2: exactly one state bit set
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(st_q) == 1);

  // R2: counter cleared after any non-iteration cycle
  p_cnt_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_RUN) |=> (cnt_q == '0));

  // R1: iteration ends after the last count
  p_run_exit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && cnt_q == CLAST && !abort_i) |=> (st_q == ST_LAST));

  // R8: offered result stays until acknowledged
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i && !abort_i) |=> req_o);

  // R8: acknowledge returns to idle
  p_ack_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && ack_i) |=> (st_q == ST_IDLE));

  // R10: abort forces idle
  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (st_q == ST_IDLE));

endmodule

// File: rtl/nrdiv_core.sv
module nrdiv_core #(
  parameter int W  = 64,
  parameter int NW = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic         step_i,
  input  logic         fin_i,
  input  logic         sgn_i,
  input  logic         wide_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] quo_o,
  output logic         sgn_o,
  output logic         wide_o,
  output logic         both_neg_o
);

  localparam int XW = W - NW;

  logic [W-1:0] dvs_ext, mag_n, mag_d;
  logic         n_neg, d_neg;

  logic [W:0]   rem_q, rem_n;
  logic [W-1:0] quo_q, quo_n;
  logic [W-1:0] dmag_q;
  logic         sub_q, sub_n;
  logic         neg_q, both_q, sgn_q, wide_q;
  logic [W+1:0] shifted, addend, rem_step;
  logic         en_rem, en_quo, en_opd;

  // divisor extension for the narrow mode
  always_comb begin
    if (wide_i)     dvs_ext = dvs_i;
    else if (sgn_i) dvs_ext = {{XW{dvs_i[NW-1]}}, dvs_i[NW-1:0]};
    else            dvs_ext = {{XW{1'b0}}, dvs_i[NW-1:0]};
  end

  assign n_neg = sgn_i & dvd_i[W-1];
  assign d_neg = sgn_i & dvs_ext[W-1];
  assign mag_n = n_neg ? (~dvd_i + 1'b1) : dvd_i;
  assign mag_d = d_neg ? (~dvs_ext + 1'b1) : dvs_ext;

  // one non-restoring step, operation chosen by the registered decision
  assign shifted  = {rem_q, quo_q[W-1]};
  assign addend   = {2'b00, dmag_q};
  assign rem_step = sub_q ? (shifted - addend) : (shifted + addend);

  always_comb begin
    rem_n = rem_q;
    quo_n = quo_q;
    sub_n = sub_q;
    if (ld_i) begin
      rem_n = '0;
      quo_n = mag_n;
      sub_n = 1'b1;
    end else if (step_i) begin
      rem_n = rem_step[W:0];
      quo_n = {quo_q[W-2:0], ~rem_step[W+1]};
      sub_n = ~rem_step[W+1];
    end else if (fin_i) begin
      quo_n = neg_q ? (~quo_q + 1'b1) : quo_q;
    end
  end

  assign en_rem = ld_i | step_i;
  assign en_quo = ld_i | step_i | fin_i;
  assign en_opd = ld_i;

  always_ff @(posedge clk) begin
    if (en_rem) begin
      rem_q <= rem_n;
      sub_q <= sub_n;
    end
    if (en_quo) quo_q <= quo_n;
    if (en_opd) begin
      dmag_q <= mag_d;
      neg_q  <= n_neg ^ d_neg;
      both_q <= n_neg & d_neg;
      sgn_q  <= sgn_i;
      wide_q <= wide_i;
    end
  end

  assign quo_o      = quo_q;
  assign sgn_o      = sgn_q;
  assign wide_o     = wide_q;
  assign both_neg_o = both_q;

  // R3: the first step after a load always subtracts
  p_first_sub_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> sub_q);

  // R3: a non-negative quotient passes the sign cycle unchanged
  p_fin_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_i && !neg_q) |=> (quo_q == $past(quo_q)));

endmodule

// File: rtl/nrdiv_sat.sv
module nrdiv_sat
  import nrdiv_pkg::*;
#(
  parameter int W  = 64,
  parameter int NW = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         chk_i,
  input  logic         fix_i,
  input  logic [W-1:0] quo_i,
  input  logic         sgn_i,
  input  logic         wide_i,
  input  logic         both_neg_i,
  output logic [W-1:0] res_o,
  output logic [7:0]   flags_o
);

  localparam int XW = W - NW;

  logic         up_zero, up33_zero, up33_one, pos_path;
  logic         ou_n, op_n, on_n;
  logic         ou_s, op_s, on_s;
  logic [W-1:0] q_s;
  logic [NW-1:0] r32;
  logic         ovf;
  logic [W-1:0] res_n, res_q;
  ccf_t         wcc, ncc;
  logic [7:0]   flags_q;

  // check stage: classify the quotient
  assign up_zero   = ~|quo_i[W-1:NW];
  assign up33_zero = ~|quo_i[W-1:NW-1];
  assign up33_one  = &quo_i[W-1:NW-1];
  assign pos_path  = ~quo_i[W-1] | both_neg_i;

  assign ou_n = ~wide_i & ~sgn_i & ~up_zero;
  assign op_n = ~wide_i & sgn_i & pos_path & ~up33_zero;
  assign on_n = ~wide_i & sgn_i & ~pos_path & ~up33_one;

  always_ff @(posedge clk) begin
    if (chk_i) begin
      q_s  <= quo_i;
      ou_s <= ou_n;
      op_s <= op_n;
      on_s <= on_n;
    end
  end

  // saturation stage
  always_comb begin
    if (ou_s)      r32 = '1;
    else if (op_s) r32 = {1'b0, {(NW-1){1'b1}}};
    else if (on_s) r32 = {1'b1, {(NW-1){1'b0}}};
    else           r32 = q_s[NW-1:0];
    ovf = ou_s | op_s | on_s;

    if (wide_i)     res_n = q_s;
    else if (sgn_i) res_n = {{XW{r32[NW-1]}}, r32};
    else            res_n = {{XW{1'b0}}, r32};

    wcc.n = q_s[W-1];
    wcc.z = ~|q_s;
    wcc.v = 1'b0;
    wcc.c = 1'b0;
    ncc.n = on_s | ou_s | (q_s[NW-1] & ~op_s);
    ncc.z = ~|q_s[NW-1:0] & ~ovf;
    ncc.v = ovf;
    ncc.c = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (fix_i) begin
      res_q   <= res_n;
      flags_q <= {wcc, ncc};
    end
  end

  assign res_o   = res_q;
  assign flags_o = flags_q;

  // R6: a signed narrow result is always a sign-extended 32-bit value
  p_sext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_i && !wide_i && sgn_i) |=> ((res_q[W-1:NW-1] == '0) || (&res_q[W-1:NW-1])));

  // R5: an unsigned narrow result never has upper bits set
  p_zext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_i && !wide_i && !sgn_i) |=> (res_q[W-1:NW] == '0));

  // R7: narrow zero and narrow overflow never both set
  p_zero_vs_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fix_i |=> !(flags_q[2] && flags_q[1]));

endmodule

// File: rtl/nrdiv_unit.sv
module nrdiv_unit #(
  parameter int W  = 64,
  parameter int NW = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic         wide_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  input  logic         abort_i,
  input  logic         ack_i,
  output logic         req_o,
  output logic [W-1:0] quot_o,
  output logic [7:0]   flags_o
);

  logic         ld, step, fin, chk, fix;
  logic [W-1:0] quo;
  logic         sgn_r, wide_r, both_neg;

  nrdiv_ctrl #(.ITER(W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .abort_i (abort_i),
    .ack_i   (ack_i),
    .ld_o    (ld),
    .step_o  (step),
    .fin_o   (fin),
    .chk_o   (chk),
    .fix_o   (fix),
    .req_o   (req_o)
  );

  nrdiv_core #(.W(W), .NW(NW)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_i       (ld),
    .step_i     (step),
    .fin_i      (fin),
    .sgn_i      (signed_i),
    .wide_i     (wide_i),
    .dvd_i      (dividend_i),
    .dvs_i      (divisor_i),
    .quo_o      (quo),
    .sgn_o      (sgn_r),
    .wide_o     (wide_r),
    .both_neg_o (both_neg)
  );

  nrdiv_sat #(.W(W), .NW(NW)) u_sat (
    .clk        (clk),
    .rst_n      (rst_n),
    .chk_i      (chk),
    .fix_i      (fix),
    .quo_i      (quo),
    .sgn_i      (sgn_r),
    .wide_i     (wide_r),
    .both_neg_i (both_neg),
    .res_o      (quot_o),
    .flags_o    (flags_o)
  );

endmodule

// File: tb/tb_nrdiv_unit.sv
module tb_nrdiv_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, signed_i, wide_i, abort_i, ack_i;
  logic [63:0] dividend_i, divisor_i;
  logic        req_o;
  logic [63:0] quot_o;
  logic [7:0]  flags_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  nrdiv_unit dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
    .wide_i(wide_i), .dividend_i(dividend_i), .divisor_i(divisor_i),
    .abort_i(abort_i), .ack_i(ack_i), .req_o(req_o), .quot_o(quot_o),
    .flags_o(flags_o)
  );

  task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected {flags, result} from the requirements
  function automatic logic [71:0] model(input logic sg, input logic wd,
                                        input logic [63:0] a, input logic [63:0] b);
    logic [63:0] d, ma, md, mq, q, res;
    logic [31:0] r32;
    logic nn, dn, ng, ov;
    d  = wd ? b : (sg ? {{32{b[31]}}, b[31:0]} : {32'b0, b[31:0]});
    nn = sg & a[63];
    dn = sg & d[63];
    ma = nn ? -a : a;
    md = dn ? -d : d;
    mq = ma / md;
    ng = nn ^ dn;
    q  = ng ? -mq : mq;
    ov = 1'b0;
    r32 = q[31:0];
    if (wd) res = q;
    else if (!sg) begin
      ov  = (mq[63:32] != 0);
      r32 = ov ? 32'hFFFF_FFFF : mq[31:0];
      res = {32'b0, r32};
    end else begin
      if (!ng && mq > 64'h7FFF_FFFF) begin ov = 1'b1; r32 = 32'h7FFF_FFFF; end
      else if (ng && mq > 64'h8000_0000) begin ov = 1'b1; r32 = 32'h8000_0000; end
      res = {{32{r32[31]}}, r32};
    end
    return {q[63], (q == 0), 2'b00, r32[31], (r32 == 0), ov, 1'b0, res};
  endfunction

  task automatic run_op(input logic sg, input logic wd, input logic [63:0] a,
                        input logic [63:0] b, input logic poke, input string rtag);
    logic [71:0] e;
    logic [63:0] held;
    int n;
    @(negedge clk);
    signed_i = sg; wide_i = wd; dividend_i = a; divisor_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (!req_o && n < 100) begin
      start_i = poke && (n == 10);         // R9: start while busy
      if (start_i) dividend_i = ~a;
      @(negedge clk);
      n++;
    end
    start_i = 1'b0;
    check("R1 R2 latency", 72'(n), 72'd67);
    e = model(sg, wd, a, b);
    check({rtag, " quotient"}, {8'h0, quot_o}, {8'h0, e[63:0]});
    check("R7 flags", {64'h0, flags_o}, {64'h0, e[71:64]});
    held = quot_o;
    for (int k = 0; k < 3; k++) begin
      start_i = (k == 1);                  // R9: start while result waits
      dividend_i = 64'h1234;
      @(negedge clk);
    end
    start_i = 1'b0;
    check("R8 R9 held", {7'h0, req_o, quot_o}, {7'h0, 1'b1, held});
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
    check("R8 ack", 72'(req_o), 72'd0);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] a, b;
    logic sg, wd;
    int seen;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 0; signed_i = 0; wide_i = 0; abort_i = 0; ack_i = 0;
    dividend_i = 0; divisor_i = 0;
    #1;
    check("R11 reset req", 72'(req_o), 72'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle after reset", 72'(req_o), 72'd0);

    // directed corner cases
    run_op(1, 1, 64'd100, 64'd7, 0, "R3");
    run_op(1, 1, -64'd100, 64'd7, 0, "R3");
    run_op(1, 1, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R3");
    run_op(0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 0, "R3");
    run_op(0, 1, 64'h0123_4567_89AB_CDEF, 64'd1, 0, "R3");
    run_op(0, 0, 64'h1_0000_0000, 64'd1, 0, "R5");
    run_op(0, 0, 64'hFFFF_FFFF, 64'd1, 0, "R5");
    run_op(1, 0, 64'hFFFF_FFFF_8000_0000, 64'h0000_0000_FFFF_FFFF, 0, "R6");
    run_op(1, 0, -(64'd1 << 40), 64'd3, 0, "R6");
    run_op(1, 0, 64'h1_0000_0000, 64'd2, 0, "R6");
    run_op(1, 0, 64'h7FFF_FFFF, 64'd1, 0, "R4");
    run_op(1, 0, 64'hFFFF_FFFF_8000_0000, 64'd1, 0, "R4");
    run_op(1, 0, 64'd1000, 64'hDEAD_0000_0000_0005, 0, "R4");
    run_op(1, 1, 64'd0, -64'd9, 0, "R7");
    run_op(1, 1, -64'd1, 64'd2, 0, "R7");

    // R10: abort during iteration
    @(negedge clk);
    signed_i = 0; wide_i = 1; dividend_i = 64'd77; divisor_i = 64'd5; start_i = 1;
    @(negedge clk);
    start_i = 0;
    repeat (20) @(negedge clk);
    abort_i = 1;
    @(negedge clk);
    abort_i = 0;
    seen = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (req_o) seen = 1;
    end
    check("R10 abort run", 72'(seen), 72'd0);
    run_op(0, 1, 64'd77, 64'd5, 0, "R2");

    // R10: abort while a result waits
    @(negedge clk);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    while (!req_o) @(negedge clk);
    abort_i = 1;
    @(negedge clk);
    abort_i = 0;
    check("R10 abort done", 72'(req_o), 72'd0);

    // R11: reset in mid-run
    @(negedge clk);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R11 reset mid-run", 72'(req_o), 72'd0);
    @(negedge clk);
    rst_n = 1'b1;
    seen = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (req_o) seen = 1;
    end
    check("R11 no result after reset", 72'(seen), 72'd0);

    // constrained random mix
    for (int i = 0; i < 40; i++) begin
      a  = {$urandom, $urandom} >> ($urandom % 64);
      b  = {$urandom, $urandom} >> ($urandom % 64);
      if ($urandom % 4 == 0) a = -a;
      if ($urandom % 4 == 0) b = -b;
      if (b[31:0] == 0) b[0] = 1'b1;
      sg = $urandom % 2;
      wd = $urandom % 2;
      run_op(sg, wd, a, b, (i % 5 == 0), (i % 5 == 0) ? "R9" : (wd ? "R3" : "R4"));
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule